// File: doc/BRIEF.md
# Serial Loopback and Timing-Mode Datapath

This block is the digital core of a 16-bit serial transceiver path. On the transmit side it takes a parallel word and shifts it onto a one-bit serial output, most significant bit first, at one bit per transmit bit enable. On the receive side it collects serial bits into parallel words, with the earliest bit in the top position. It also raises a strobe for each completed word. All bit clocks are modelled as single-cycle enables on one system clock. One enable comes from the reference clock and the other from the recovered line clock.

Four static controls steer the data. Retimed line loopback sends received bits back out after one register stage. Analog loopback sends the raw line bit out combinationally. Diagnostic loopback feeds the transmit serial stream into the receiver in place of the line. Loop timing clocks the transmit shifter from the recovered enable. The controls are captured only when the transmitter takes a new word, so no transmitted word is ever split across two modes. A line-fault flag reports loss of signal, except while diagnostic loopback is active.

Top module: `serial_loop_path`

## Requirements
- R1: In the cycle where a selected transmit bit enable arrives with all 16 bits of the current word already sent (including the first enable after reset), `tx_take` is high and `tx_word` is captured. The shifter output then presents word bit 15 and moves to bits 14 down to 0, one per later enable.
- R2: `tx_word_clk` is low for the first eight bit periods of each transmitted word and high for the last eight. It changes only on a selected transmit bit enable.
- R3: Received bits are assembled in arrival order. After the 16th bit, `rx_word` holds the first bit in bit 15 and the last in bit 0, and `rx_word_vld` is high for one cycle. `rx_word` changes only in a cycle where `rx_word_clk` falls.
- R4: While retimed line loopback is in force, `ser_out` equals the `line_in` value captured at the most recent `rec_bit_en`, which is one register stage. The receive word path keeps deserializing the line.
- R5: While analog loopback is in force and retimed loopback is not, `ser_out` follows `line_in` in the same cycle.
- R6: With both line loopbacks off, `ser_out` carries the transmit shifter bit.
- R7: While diagnostic loopback is in force, the receiver samples the transmit bit that enters the line at each transmit enable and ignores `line_in`. Each returned `rx_word` equals the last word captured by `tx_take`.
- R8: `line_fault` is the inverse of `sig_det`, except that it is held low while diagnostic loopback is in force.
- R9: While loop timing is in force, the transmit shifter advances on `rec_bit_en` and ignores `ref_bit_en`.
- R10: The four `cfg_*` inputs are captured only in a `tx_take` cycle. The output select, loop timing and fault masking use the new value from the following cycle. The receive source switches in the take cycle itself, and a change of receive source discards the partial word, so assembly restarts with that cycle's bit.
- R11: After reset, `ser_out`, `rx_word` and `rx_word_vld` are 0, all modes are off, and the first selected transmit enable captures a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_bit_en | input | 1 | Bit enable derived from the reference clock |
| rec_bit_en | input | 1 | Bit enable recovered from the line; `line_in` is valid with it |
| line_in | input | 1 | Serial line input bit |
| sig_det | input | 1 | Signal present on the line |
| tx_word | input | 16 | Parallel transmit word, captured on `tx_take` |
| cfg_line_retime | input | 1 | Retimed line loopback request (highest priority) |
| cfg_analog_loop | input | 1 | Non-retimed line loopback request |
| cfg_diag_loop | input | 1 | Diagnostic loopback request |
| cfg_loop_time | input | 1 | Loop timing request |
| tx_take | output | 1 | Transmit word captured this cycle |
| tx_word_clk | output | 1 | Transmit bit clock divided by 16 |
| ser_out | output | 1 | Serial output bit |
| rx_word | output | 16 | Parallel receive word |
| rx_word_vld | output | 1 | One-cycle strobe for a new receive word |
| rx_word_clk | output | 1 | Receive bit clock divided by 16 |
| line_fault | output | 1 | Loss of line signal, masked in diagnostic loopback |

## Verification
The bench targets mode requests that change in the middle of a word. A design that applied them at once would switch `ser_out` to the new source before the next `tx_take` and would be caught. It also covers entry into and exit from diagnostic loopback. A receiver that did not discard its partial word there would return words shifted by a few bits instead of the words just transmitted. Loop timing is run with the reference enable silenced, so a shifter still tied to `ref_bit_en` stalls and loses `tx_take`. Running both loopback requests at once exposes a wrong mux priority, and a retime path with an extra or a missing stage shows up as `ser_out` one recovered bit off.

// File: rtl/slp_pkg.sv
package slp_pkg;

    // Mode controls as captured at a transmit word boundary
    typedef struct packed {
        logic line_rt;    // retimed line loopback
        logic analog;     // raw line loopback
        logic diag;       // transmit stream into receiver
        logic loop_time;  // recovered enable clocks the shifter
    } loop_mode_t;

    localparam loop_mode_t MODE_NONE = '{line_rt: 1'b0, analog: 1'b0, diag: 1'b0, loop_time: 1'b0};

endpackage

// File: rtl/slp_tx_shifter.sv
module slp_tx_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic [W-1:0] word_in,
    output logic         take,
    output logic         cur_bit,
    output logic         next_bit,
    output logic         word_clk
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t st_q, st_d;
    logic   take_c;

    always_comb begin
        st_d   = st_q;
        take_c = bit_en && (st_q.cnt == LAST);
        if (bit_en) begin
            if (take_c) begin
                st_d.sh  = word_in;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = st_q.sh << 1;
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign take     = take_c;
    assign cur_bit  = st_q.sh[W-1];
    assign next_bit = (st_q.cnt == LAST) ? word_in[W-1] : st_q.sh[W-2];
    assign word_clk = st_q.cnt[CW-1];

    AST_TX_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cur_bit == $past(word_in[W-1])); // R1
    AST_TX_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(word_clk)); // R2

endmodule

// File: rtl/slp_rx_deser.sv
module slp_rx_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         restart,
    output logic [W-1:0] word_out,
    output logic         word_vld,
    output logic         word_clk
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-2:0]  des;
        logic [CW-1:0] cnt;
        logic [W-1:0]  word;
        logic          vld;
    } rx_st_t;

    rx_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (bit_en) begin
            st_d.des = {st_q.des[W-3:0], bit_in};
            if (restart) begin
                st_d.cnt = CW'(1);
            end else if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.word = {st_q.des, bit_in};
                st_d.vld  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else if (restart) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out = st_q.word;
    assign word_vld = st_q.vld;
    assign word_clk = st_q.cnt[CW-1];

    AST_RX_WORD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> $fell(word_clk)); // R3
    AST_RX_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R3

endmodule

// File: rtl/slp_mode_latch.sv
module slp_mode_latch
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  loop_mode_t cfg,
    output loop_mode_t mode_q,
    output logic       diag_eff,
    output logic       rx_restart
);
    loop_mode_t mode_d;

    always_comb begin
        mode_d     = load ? cfg : mode_q;
        diag_eff   = mode_d.diag;
        rx_restart = load && (cfg.diag != mode_q.diag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NONE;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/serial_loop_path.sv
module serial_loop_path
    import slp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_bit_en,
    input  logic         rec_bit_en,
    input  logic         line_in,
    input  logic         sig_det,
    input  logic [W-1:0] tx_word,
    input  logic         cfg_line_retime,
    input  logic         cfg_analog_loop,
    input  logic         cfg_diag_loop,
    input  logic         cfg_loop_time,
    output logic         tx_take,
    output logic         tx_word_clk,
    output logic         ser_out,
    output logic [W-1:0] rx_word,
    output logic         rx_word_vld,
    output logic         rx_word_clk,
    output logic         line_fault
);
    loop_mode_t cfg_in, mode_q;
    logic       diag_eff, rx_restart;
    logic       tx_en, take_w, cur_bit, next_bit;
    logic       rx_en, rx_bit;
    logic       ret_q, ret_d;

    assign cfg_in = '{line_rt: cfg_line_retime, analog: cfg_analog_loop,
                      diag: cfg_diag_loop, loop_time: cfg_loop_time};

    slp_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_w),
        .cfg        (cfg_in),
        .mode_q     (mode_q),
        .diag_eff   (diag_eff),
        .rx_restart (rx_restart)
    );

    slp_tx_shifter #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (tx_en),
        .word_in  (tx_word),
        .take     (take_w),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .word_clk (tx_word_clk)
    );

    slp_rx_deser #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (rx_en),
        .bit_in   (rx_bit),
        .restart  (rx_restart),
        .word_out (rx_word),
        .word_vld (rx_word_vld),
        .word_clk (rx_word_clk)
    );

    always_comb begin
        tx_en  = mode_q.loop_time ? rec_bit_en : ref_bit_en;
        rx_en  = diag_eff ? tx_en : rec_bit_en;
        rx_bit = diag_eff ? next_bit : line_in;
        ret_d  = rec_bit_en ? line_in : ret_q;
        if (mode_q.line_rt) begin
            ser_out = ret_q;
        end else if (mode_q.analog) begin
            ser_out = line_in;
        end else begin
            ser_out = cur_bit;
        end
        line_fault = !sig_det && !mode_q.diag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= 1'b0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign tx_take = take_w;

    AST_RETIME_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.line_rt && $past(rec_bit_en)) |-> ser_out == $past(line_in)); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_take |=> $stable(mode_q)); // R10
    AST_FAULT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.diag |-> !line_fault); // R8
    AST_LOOP_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.loop_time && !rec_bit_en) |=> $stable(tx_word_clk)); // R9

endmodule

// File: tb/serial_loop_path_tb.sv
module serial_loop_path_tb;
    localparam int MAX_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_bit_en, rec_bit_en, line_in, sig_det;
    logic [15:0] tx_word;
    logic        c_rt, c_an, c_dg, c_lt;
    logic        tx_take, tx_word_clk, ser_out, rx_word_vld, rx_word_clk, line_fault;
    logic [15:0] rx_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench reference state
    logic [15:0] m_sh, m_des, m_rword, last_taken;
    logic [3:0]  m_cnt, m_rcnt;
    logic        m_vld, m_ret;
    logic        m_rt, m_an, m_dg, m_lt;

    always #5 clk = ~clk;

    serial_loop_path u_dut (
        .clk(clk), .rst_n(rst_n), .ref_bit_en(ref_bit_en), .rec_bit_en(rec_bit_en),
        .line_in(line_in), .sig_det(sig_det), .tx_word(tx_word),
        .cfg_line_retime(c_rt), .cfg_analog_loop(c_an), .cfg_diag_loop(c_dg),
        .cfg_loop_time(c_lt), .tx_take(tx_take), .tx_word_clk(tx_word_clk),
        .ser_out(ser_out), .rx_word(rx_word), .rx_word_vld(rx_word_vld),
        .rx_word_clk(rx_word_clk), .line_fault(line_fault)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_ser();
        if (m_rt) return m_ret;
        if (m_an) return line_in;
        return m_sh[15];
    endfunction

    task automatic model_reset();
        m_sh = '0; m_des = '0; m_rword = '0; m_cnt = 4'd15; m_rcnt = '0;
        m_vld = 0; m_ret = 0; m_rt = 0; m_an = 0; m_dg = 0; m_lt = 0;
        last_taken = '0;
    endtask

    // compare outputs against the reference, then advance it by one edge
    task automatic check_and_advance();
        logic tx_en, load, e_dg, rst_rx, nb, rx_en, rx_b;
        string sreq;
        tx_en  = m_lt ? rec_bit_en : ref_bit_en;
        load   = tx_en && (m_cnt == 4'd15);
        if ({c_lt, c_dg, c_an, c_rt} != {m_lt, m_dg, m_an, m_rt}) sreq = "R10";
        else if (m_rt) sreq = "R4";
        else if (m_an) sreq = "R5";
        else sreq = "R6";
        chk(sreq, "ser_out", 16'(ser_out), 16'(exp_ser()));
        chk(m_lt ? "R9" : "R1", "tx_take", 16'(tx_take), 16'(load));
        chk("R2", "tx_word_clk", 16'(tx_word_clk), 16'(m_cnt[3]));
        chk("R3", "rx_word_clk", 16'(rx_word_clk), 16'(m_rcnt[3]));
        chk("R3", "rx_word_vld", 16'(rx_word_vld), 16'(m_vld));
        chk("R3", "rx_word", rx_word, m_rword);
        chk("R8", "line_fault", 16'(line_fault), 16'(!sig_det && !m_dg));
        if (rx_word_vld && m_dg) chk("R7", "diag return word", rx_word, last_taken);
        if (load) last_taken = tx_word;

        e_dg   = load ? c_dg : m_dg;
        rst_rx = load && (c_dg != m_dg);
        nb     = (m_cnt == 4'd15) ? tx_word[15] : m_sh[14];
        rx_en  = e_dg ? tx_en : rec_bit_en;
        rx_b   = e_dg ? nb : line_in;
        m_vld  = 0;
        if (rx_en) begin
            m_des = {m_des[14:0], rx_b};
            if (rst_rx) m_rcnt = 4'd1;
            else if (m_rcnt == 4'd15) begin
                m_rcnt = 0; m_rword = m_des; m_vld = 1;
            end else m_rcnt = m_rcnt + 4'd1;
        end else if (rst_rx) m_rcnt = 0;
        if (tx_en) begin
            if (load) begin m_sh = tx_word; m_cnt = 0; end
            else begin m_sh = m_sh << 1; m_cnt = m_cnt + 4'd1; end
        end
        if (rec_bit_en) m_ret = line_in;
        if (load) {m_lt, m_dg, m_an, m_rt} = {c_lt, c_dg, c_an, c_rt};
    endtask

    task automatic run_phase(input logic [3:0] cfg, input int cycles);
        {c_lt, c_dg, c_an, c_rt} = cfg;
        sig_det = 1'($urandom % 2);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ref_bit_en = (cfg[3] && i > cycles / 2) ? 1'b0 : 1'($urandom % 2);
            rec_bit_en = ($urandom % 3) == 0;
            line_in    = 1'($urandom % 2);
            tx_word    = 16'($urandom);
            if (i % 97 == 0) sig_det = ~sig_det;
            #1;
            check_and_advance();
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 0; ref_bit_en = 0; rec_bit_en = 0; line_in = 0; sig_det = 1;
        tx_word = 16'hA5C3; c_rt = 0; c_an = 0; c_dg = 0; c_lt = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R11: reset state before any enable
        chk("R11", "ser_out after reset", 16'(ser_out), 16'h0);
        chk("R11", "rx_word after reset", rx_word, 16'h0);
        chk("R11", "rx_word_vld after reset", 16'(rx_word_vld), 16'h0);
        check_and_advance();
        // R11: first reference enable captures a word
        @(negedge clk); ref_bit_en = 1; #1;
        chk("R11", "first take", 16'(tx_take), 16'h1);
        check_and_advance();
        @(negedge clk); ref_bit_en = 0; #1;
        chk("R1", "msb first", 16'(ser_out), 16'(tx_word[15]));
        check_and_advance();

        run_phase(4'b0000, 600);
        run_phase(4'b0001, 600);
        run_phase(4'b0010, 600);
        run_phase(4'b0011, 600);
        run_phase(4'b0100, 800);
        run_phase(4'b0000, 400);
        run_phase(4'b1000, 800);
        run_phase(4'b1100, 800);
        run_phase(4'b1001, 600);
        run_phase(4'b0110, 600);
        for (int p = 0; p < 10; p++) run_phase(4'($urandom), 500);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule